// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a last-in-first-out stack whose storage is a set of shift-register columns, one column per data bit, rather than an addressed memory with a pointer. Every stored word moves on each push or pop. A push sends every entry one slot deeper and writes the incoming word into the top slot. A pop moves every entry one slot toward the top, fills the deepest slot with zeros and discards the old top.

A two-bit operation code selects the operation. The code 00 holds, 01 pushes and 10 pops. The code 11 is reserved and acts as hold. A small decoder turns this code into per-column controls: clock enable, parallel load, shift direction and clear. Those controls drive all columns and an occupancy counter. The output always shows the current top entry, taken straight from the top slot of the columns. A pop does not return the removed value; after a pop the output shows the entry that was beneath it. A synchronous active-low reset empties the whole stack.

The default build is five bits wide and four entries deep. Both values are parameters.

Top module: `shift_lifo`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every entry is cleared. After that edge `top_data` is 0 and `level` is 0.
- R2: With `op` = 01 (push), `top_data` equals the sampled `push_data` after the edge.
- R3: With `op` = 10 (pop), after the edge `top_data` shows the entry that was second from the top, and the popped word is no longer held anywhere in the stack.
- R4: With `op` = 00 (hold), neither `top_data` nor `level` changes across the edge.
- R5: The code `op` = 11 behaves exactly like hold.
- R6: A pop on an empty stack (`level` = 0) leaves `top_data` at 0 and `level` at 0.
- R7: A push onto a full stack (`level` = DEPTH) writes the new top and drops the deepest entry. `level` stays at DEPTH and no error is signalled.
- R8: Each pop shifts a zero into the deepest slot, so once the stack has been popped past its contents, `top_data` reads 0.
- R9: After pushing 5, 3 and 4 in that order, the top is 4. Three pops then show 3, then 5, then 0.
- R10: `level` counts the stored entries. It rises by one on a push below DEPTH, falls by one on a pop above 0, and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; empties the stack |
| op | input | 2 | Operation: 00 hold, 01 push, 10 pop, 11 hold |
| push_data | input | WIDTH | Word written to the top on a push |
| top_data | output | WIDTH | Current top-of-stack entry |
| level | output | $clog2(DEPTH+1) | Number of entries currently stored |

## Verification
The bound checker watches, on every cycle, the cycle-to-cycle rules that can be seen at the ports:
- a pushed word appears on top;
- hold and the reserved code change nothing;
- pops on an empty stack stay at zero;
- the occupancy count moves by one and saturates at both ends;
- reset empties the stack.

Only the bench scenarios can show the deeper ordering behaviour, because the entries below the top are not visible on the ports. This covers the reappearance of older words after pops, the loss of the deepest word when a full stack is pushed, zero fill after over-popping, and the worked example sequence. The bench checks these against a reference model of the stack.

// File: rtl/shift_lifo_pkg.sv
// Package: shared operation encoding and column-control bundle for the
// shift-register LIFO. Assumes a two-bit operation code.
package shift_lifo_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_RSVD = 2'b11
    } stk_op_e;

    // Controls shared by every bit column and the occupancy counter.
    typedef struct packed {
        logic ce;    // clock enable: column updates on this edge
        logic load;  // parallel load from the column's parallel input
        logic left;  // 1: shift deeper (push), 0: shift toward top (pop)
        logic clr;   // synchronous clear of the whole column
    } col_ctl_t;

endpackage

// File: rtl/shift_lifo_decode.sv
// Module: shift_lifo_decode
// Turns the stack operation code and the reset into column controls.
// Assumes: reset dominates; the reserved code behaves as hold; parallel
// load is never requested by a stack operation.
module shift_lifo_decode
    import shift_lifo_pkg::*;
(
    input  logic       rst_n,
    input  logic [1:0] op,
    output col_ctl_t   ctl
);

    // Purpose: map reset and operation code to clock enable, load, direction, clear.
    always_comb begin
        ctl = '0;
        if (!rst_n) begin
            ctl.clr = 1'b1;
        end else begin
            unique case (stk_op_e'(op))
                OP_PUSH: begin
                    ctl.ce   = 1'b1;
                    ctl.left = 1'b1;
                end
                OP_POP: begin
                    ctl.ce   = 1'b1;
                    ctl.left = 1'b0;
                end
                OP_HOLD, OP_RSVD: begin
                    ctl.ce = 1'b0;
                end
                default: ctl.ce = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/shift_lifo_column.sv
// Module: shift_lifo_column
// One bit position of the stack: a DEPTH-long shift register. Slot 0 is
// the top. Shifting left moves bits deeper and takes ser_in into slot 0.
// Shifting right moves bits toward the top and fills the deepest slot
// with zero. Assumes DEPTH >= 2.
module shift_lifo_column
    import shift_lifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  col_ctl_t         ctl,
    input  logic             ser_in,
    input  logic [DEPTH-1:0] par_in,
    output logic [DEPTH-1:0] q
);

    // Purpose: clear, load or shift the column when enabled.
    always_ff @(posedge clk) begin
        if (ctl.clr) begin
            q <= '0;
        end else if (ctl.ce) begin
            if (ctl.load) begin
                q <= par_in;
            end else if (ctl.left) begin
                q <= {q[DEPTH-2:0], ser_in};
            end else begin
                q <= {1'b0, q[DEPTH-1:1]};
            end
        end
    end

endmodule

// File: rtl/shift_lifo_level.sv
// Module: shift_lifo_level
// Occupancy counter that follows the column controls. It saturates at
// DEPTH on push and at zero on pop. Assumes the same controls as the columns.
module shift_lifo_level
    import shift_lifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  col_ctl_t         ctl,
    output logic [LVL_W-1:0] level
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    // Purpose: count entries, saturating at both ends.
    always_ff @(posedge clk) begin
        if (ctl.clr) begin
            level <= '0;
        end else if (ctl.ce && !ctl.load) begin
            if (ctl.left) begin
                if (level != FULL) level <= level + 1'b1;
            end else begin
                if (level != '0) level <= level - 1'b1;
            end
        end
    end

endmodule

// File: rtl/shift_lifo.sv
// Module: shift_lifo (top)
// LIFO stack built from WIDTH shift-register columns of DEPTH slots each.
// The top entry is read directly from slot 0 of every column.
// Assumes a synchronous active-low reset and DEPTH >= 2.
module shift_lifo
    import shift_lifo_pkg::*;
#(
    parameter int WIDTH = 5,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data,
    output logic [LVL_W-1:0] level
);

    col_ctl_t ctl;

    shift_lifo_decode u_decode (
        .rst_n (rst_n),
        .op    (op),
        .ctl   (ctl)
    );

    // One shift-register column per data bit; slot 0 of each drives the output.
    for (genvar b = 0; b < WIDTH; b++) begin : g_col
        logic [DEPTH-1:0] col_q;

        shift_lifo_column #(.DEPTH(DEPTH)) u_col (
            .clk    (clk),
            .ctl    (ctl),
            .ser_in (push_data[b]),
            .par_in ('0),
            .q      (col_q)
        );

        assign top_data[b] = col_q[0];
    end

    shift_lifo_level #(.DEPTH(DEPTH)) u_level (
        .clk   (clk),
        .ctl   (ctl),
        .level (level)
    );

endmodule

// File: rtl/shift_lifo_chk.sv
// Module: shift_lifo_chk
// Port-level protocol checker for shift_lifo, attached by bind.
module shift_lifo_chk #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] push_data,
    input logic [WIDTH-1:0] top_data,
    input logic [LVL_W-1:0] level
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic rst_seen_low;

    // Purpose: remember that the previous edge sampled reset asserted.
    always_ff @(posedge clk) rst_seen_low <= !rst_n;

    // Purpose: after a reset edge the stack reads empty (R1).
    always @(negedge clk) begin
        if (rst_seen_low === 1'b1) begin
            assert_reset_clears_R1: assert (top_data == '0 && level == '0)
                else $error("R1 reset did not empty stack");
        end
    end

    assert_push_on_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b01 |=> top_data == $past(push_data));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b00 |=> $stable(top_data) && $stable(level));

    assert_rsvd_is_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == 2'b11 |=> $stable(top_data) && $stable(level));

    assert_empty_pop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10 && level == '0) |=> top_data == '0 && level == '0);

    assert_full_push_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && level == FULL) |=> level == FULL);

    assert_level_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b01 && level != FULL) |=> level == $past(level) + 1'b1);

    assert_level_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'b10 && level != '0) |=> level == $past(level) - 1'b1);

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);

endmodule

bind shift_lifo shift_lifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .push_data (push_data),
    .top_data  (top_data),
    .level     (level)
);

// File: tb/shift_lifo_tb_top.sv
// Bench for shift_lifo: directed corner cases plus seeded random operations,
// compared with a reference stack model held in the bench.
module shift_lifo_tb_top;

    localparam int W  = 5;
    localparam int D  = 4;
    localparam int LW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [W-1:0]  push_data = '0;
    logic [W-1:0]  top_data;
    logic [LW-1:0] level;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] mdl [D];
    int           mlvl;

    always #10 clk = ~clk;

    shift_lifo #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .push_data (push_data),
        .top_data  (top_data),
        .level     (level)
    );

    // Purpose: compare one value and count the check.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Purpose: reference model of one clock edge.
    task automatic model_step(input logic r_n, input logic [1:0] o, input logic [W-1:0] d);
        if (!r_n) begin
            for (int i = 0; i < D; i++) mdl[i] = '0;
            mlvl = 0;
        end else if (o == 2'b01) begin
            for (int i = D - 1; i > 0; i--) mdl[i] = mdl[i-1];
            mdl[0] = d;
            if (mlvl < D) mlvl++;
        end else if (o == 2'b10) begin
            for (int i = 0; i < D - 1; i++) mdl[i] = mdl[i+1];
            mdl[D-1] = '0;
            if (mlvl > 0) mlvl--;
        end
    endtask

    // Purpose: apply one operation at a negedge, then wait for the edge and settle.
    task automatic step(input logic [1:0] o, input logic [W-1:0] d);
        op = o;
        push_data = d;
        @(posedge clk);
        model_step(rst_n, o, d);
        @(negedge clk);
    endtask

    task automatic check_model(input string req);
        check({req, " top"}, int'(top_data), int'(mdl[0]));
        check({req, " level"}, int'(level), mlvl);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2'b00, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20051020);
        for (int i = 0; i < D; i++) mdl[i] = '0;
        mlvl = 0;
        @(negedge clk);
        // R1: reset state
        do_reset();
        check("R1 top", int'(top_data), 0);
        check("R1 level", int'(level), 0);

        // R9: worked example
        step(2'b01, 5'd5);
        step(2'b01, 5'd3);
        step(2'b01, 5'd4);
        check("R9 top after pushes", int'(top_data), 4);
        step(2'b10, '0);
        check("R9 R3 first pop", int'(top_data), 3);
        step(2'b10, '0);
        check("R9 R3 second pop", int'(top_data), 5);
        step(2'b10, '0);
        check("R9 R8 third pop", int'(top_data), 0);
        check("R10 level empty", int'(level), 0);

        // R6: pop on empty
        step(2'b10, 5'd31);
        check_model("R6");

        // R7: overfill drops the deepest entry
        for (int i = 1; i <= D + 1; i++) step(2'b01, 5'(i));
        check("R7 level full", int'(level), D);
        check("R2 top is last push", int'(top_data), D + 1);
        for (int i = 0; i < D; i++) begin
            check("R7 R3 pop order", int'(top_data), D + 1 - i);
            step(2'b10, '0);
        end
        check("R7 R8 deepest dropped, zero fill", int'(top_data), 0);

        // R4 / R5: hold and reserved code
        step(2'b01, 5'd17);
        step(2'b01, 5'd9);
        step(2'b00, 5'd30);
        check_model("R4");
        step(2'b11, 5'd30);
        check_model("R5");
        step(2'b10, '0);
        check("R5 R3 contents kept", int'(top_data), 17);

        // R1: reset in mid-run
        do_reset();
        check("R1 mid-run top", int'(top_data), 0);
        check("R1 mid-run level", int'(level), 0);
        step(2'b10, '0);
        check("R1 R8 nothing left", int'(top_data), 0);

        // R2 R3 R10: seeded random operations
        for (int n = 0; n < 400; n++) begin
            logic [1:0] o;
            int r;
            r = int'($urandom_range(0, 9));
            o = (r < 4) ? 2'b01 : (r < 8) ? 2'b10 : 2'(r - 8) ? 2'b11 : 2'b00;
            step(o, 5'($urandom_range(0, 31)));
            check_model("R2 R3 R10 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule